// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. A walk begins with a one-cycle start strobe. The block then issues a read for a first-level descriptor, indexed from the table base by the top twelve address bits, and decodes the descriptor's two type bits. A descriptor may map a 1 MB section directly, or it may point to a coarse or a fine second-level table. When it points to a table, the block fetches a second-level descriptor. That descriptor maps a 64 KB, 4 KB or 1 KB page.

The memory port uses request/response signalling. The request and its address stay asserted until the memory answers with an acknowledge or an error. At the end of every walk the block pulses a done signal and presents four results: the physical address, a 2-bit cacheable/bufferable attribute, a fault flag and a cause code. These results stay unchanged until the next walk finishes. A configuration flag decides whether fine tables (and so 1 KB indexing at first level) are legal. The block samples this flag at start.

Top module: `xlat_walker`

## Requirements
- R1: The first read of a walk uses address {base[31:14], va[31:20], 2'b00}.
- R2: A first-level descriptor with bits [1:0]=0 ends the walk after one read, with fault=1, cause=2'b01, paddr=0 and attr=0.
- R3: A first-level descriptor with bits [1:0]=3 while the fine-table flag (sampled at start) is 0 ends the walk after one read as a fault with cause=2'b01.
- R4: A first-level descriptor with bits [1:0]=2 ends the walk after one read with paddr={desc[31:20], va[19:0]}, attr=desc[3:2], fault=0, cause=2'b00.
- R5: A first-level descriptor with bits [1:0]=1 causes a second read at {desc[31:10], va[19:12], 2'b00}.
- R6: A first-level descriptor with bits [1:0]=3 while the fine-table flag is 1 causes a second read at {desc[31:12], va[19:10], 2'b00}.
- R7: A second-level descriptor with bits [1:0]=0 ends the walk with fault=1, cause=2'b10, paddr=0 and attr=0.
- R8: A second-level descriptor with bits [1:0]=1 gives paddr={desc[31:16], va[15:0]} and attr=desc[3:2].
- R9: A second-level descriptor with bits [1:0]=2 gives paddr={desc[31:12], va[11:0]} and attr=desc[3:2].
- R10: A second-level descriptor with bits [1:0]=3 gives paddr={desc[31:10], va[9:0]} and attr=desc[3:2].
- R11: An error response to either read ends the walk at once with fault=1, cause=2'b11, paddr=0, attr=0, and no further read is made.
- R12: A start received while a walk is busy (including the cycle in which its last response arrives) is ignored. Done is a one-cycle pulse. paddr, attr, fault and cause hold between completions.
- R13: The memory request stays high with an unchanged address until a cycle in which ack or err is seen. After reset, done, fault and the request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (honoured only when idle) |
| vaddr_i | input | 32 | Virtual address to translate |
| tbase_i | input | 32 | Translation table base; bits 31:14 used |
| fine_en_i | input | 1 | Allows fine tables at first level |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor byte address |
| mem_ack_i | input | 1 | Read data valid this cycle |
| mem_err_i | input | 1 | Read failed this cycle |
| mem_rdata_i | input | 32 | Descriptor word |
| done_o | output | 1 | One-cycle walk completion pulse |
| paddr_o | output | 32 | Translated physical address |
| attr_o | output | 2 | Cacheable/bufferable bits |
| fault_o | output | 1 | Walk ended in a fault |
| cause_o | output | 2 | 00 none, 01 first-level, 10 second-level, 11 bus error |

## Verification
A new start can arrive in the same cycle that the final memory response retires a walk. The design must then finish the old walk and discard the start. The bench provokes this by keeping start high, with a different address, base and flag, from the cycle after launch until done is seen. It judges the outcome in two ways: the results must match the original request, and no further read may appear afterwards. Random descriptors with random response latency and occasional error responses move the completion edge across every path.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int ADDR_W   = 32;
    localparam int TYPE_W   = 2;
    localparam int ATTR_W   = 2;
    localparam int TBASE_LO = 14;
    localparam int L1_IDX_LO = 20;
    localparam int COARSE_LO = 10;
    localparam int FINE_LO   = 12;
    localparam int LARGE_OFS = 16;
    localparam int SMALL_OFS = 12;
    localparam int TINY_OFS  = 10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_L1   = 2'd1,
        ST_L2   = 2'd2
    } walk_st_e;

    typedef enum logic [1:0] {
        L1_FAULT   = 2'd0,
        L1_SECTION = 2'd1,
        L1_TABLE   = 2'd2
    } l1_kind_e;

    localparam logic [1:0] CAUSE_NONE = 2'b00;
    localparam logic [1:0] CAUSE_L1   = 2'b01;
    localparam logic [1:0] CAUSE_L2   = 2'b10;
    localparam logic [1:0] CAUSE_BUS  = 2'b11;

    // keep the upper bits of base, the low ofs bits of the address
    function automatic logic [ADDR_W-1:0] splice(input logic [ADDR_W-1:0] base,
                                                 input logic [ADDR_W-1:0] low,
                                                 input int ofs);
        logic [ADDR_W-1:0] m;
        m = (ADDR_W'(1) << ofs) - ADDR_W'(1);
        return (base & ~m) | (low & m);
    endfunction
endpackage

// File: rtl/xlat_l1_decode.sv
module xlat_l1_decode
    import xlat_pkg::*;
(
    input  logic [ADDR_W-1:0] desc_i,
    input  logic [ADDR_W-1:0] va_i,
    input  logic              fine_en_i,
    output l1_kind_e          kind_o,
    output logic [ADDR_W-1:0] sect_pa_o,
    output logic [ADDR_W-1:0] l2_addr_o,
    output logic [ATTR_W-1:0] attr_o
);
    logic [ADDR_W-1:0] coarse_a, fine_a;

    always_comb begin
        coarse_a = {desc_i[ADDR_W-1:COARSE_LO], va_i[L1_IDX_LO-1:SMALL_OFS], 2'b00};
        fine_a   = {desc_i[ADDR_W-1:FINE_LO],   va_i[L1_IDX_LO-1:TINY_OFS],  2'b00};
        sect_pa_o = splice(desc_i, va_i, L1_IDX_LO);
        attr_o    = desc_i[3:2];
        l2_addr_o = coarse_a;
        unique case (desc_i[TYPE_W-1:0])
            2'd0: kind_o = L1_FAULT;
            2'd1: kind_o = L1_TABLE;
            2'd2: kind_o = L1_SECTION;
            default: begin
                kind_o    = fine_en_i ? L1_TABLE : L1_FAULT;
                l2_addr_o = fine_a;
            end
        endcase
    end
endmodule

// File: rtl/xlat_l2_decode.sv
module xlat_l2_decode
    import xlat_pkg::*;
(
    input  logic [ADDR_W-1:0] desc_i,
    input  logic [ADDR_W-1:0] va_i,
    output logic              fault_o,
    output logic [ADDR_W-1:0] pa_o,
    output logic [ATTR_W-1:0] attr_o
);
    always_comb begin
        attr_o  = desc_i[3:2];
        fault_o = 1'b0;
        unique case (desc_i[TYPE_W-1:0])
            2'd0: begin
                fault_o = 1'b1;
                pa_o    = '0;
            end
            2'd1:    pa_o = splice(desc_i, va_i, LARGE_OFS);
            2'd2:    pa_o = splice(desc_i, va_i, SMALL_OFS);
            default: pa_o = splice(desc_i, va_i, TINY_OFS);
        endcase
    end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] vaddr_i,
    input  logic [ADDR_W-1:0] tbase_i,
    input  logic              fine_en_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_ack_i,
    input  logic              mem_err_i,
    input  logic [ADDR_W-1:0] mem_rdata_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] paddr_o,
    output logic [ATTR_W-1:0] attr_o,
    output logic              fault_o,
    output logic [1:0]        cause_o
);
    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] va;
        logic              fine;
        logic [ADDR_W-1:0] maddr;
        logic              done;
        logic [ADDR_W-1:0] pa;
        logic [ATTR_W-1:0] attr;
        logic              fault;
        logic [1:0]        cause;
    } walk_s;

    walk_s walk_d, walk_q;

    l1_kind_e          l1_kind;
    logic [ADDR_W-1:0] l1_pa, l1_next;
    logic [ATTR_W-1:0] l1_attr, l2_attr;
    logic              l2_fault;
    logic [ADDR_W-1:0] l2_pa;

    xlat_l1_decode u_l1 (
        .desc_i    (mem_rdata_i),
        .va_i      (walk_q.va),
        .fine_en_i (walk_q.fine),
        .kind_o    (l1_kind),
        .sect_pa_o (l1_pa),
        .l2_addr_o (l1_next),
        .attr_o    (l1_attr)
    );

    xlat_l2_decode u_l2 (
        .desc_i  (mem_rdata_i),
        .va_i    (walk_q.va),
        .fault_o (l2_fault),
        .pa_o    (l2_pa),
        .attr_o  (l2_attr)
    );

    always_comb begin
        walk_d      = walk_q;
        walk_d.done = 1'b0;
        unique case (walk_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    walk_d.st    = ST_L1;
                    walk_d.va    = vaddr_i;
                    walk_d.fine  = fine_en_i;
                    walk_d.maddr = {tbase_i[ADDR_W-1:TBASE_LO],
                                    vaddr_i[ADDR_W-1:L1_IDX_LO], 2'b00};
                end
            end
            ST_L1: begin
                if (mem_err_i) begin
                    walk_d.st = ST_IDLE; walk_d.done = 1'b1; walk_d.fault = 1'b1;
                    walk_d.cause = CAUSE_BUS; walk_d.pa = '0; walk_d.attr = '0;
                end else if (mem_ack_i) begin
                    unique case (l1_kind)
                        L1_SECTION: begin
                            walk_d.st = ST_IDLE; walk_d.done = 1'b1; walk_d.fault = 1'b0;
                            walk_d.cause = CAUSE_NONE; walk_d.pa = l1_pa; walk_d.attr = l1_attr;
                        end
                        L1_TABLE: begin
                            walk_d.st    = ST_L2;
                            walk_d.maddr = l1_next;
                        end
                        default: begin
                            walk_d.st = ST_IDLE; walk_d.done = 1'b1; walk_d.fault = 1'b1;
                            walk_d.cause = CAUSE_L1; walk_d.pa = '0; walk_d.attr = '0;
                        end
                    endcase
                end
            end
            default: begin
                if (mem_err_i || mem_ack_i) begin
                    walk_d.st   = ST_IDLE;
                    walk_d.done = 1'b1;
                    if (mem_err_i) begin
                        walk_d.fault = 1'b1; walk_d.cause = CAUSE_BUS;
                        walk_d.pa = '0; walk_d.attr = '0;
                    end else if (l2_fault) begin
                        walk_d.fault = 1'b1; walk_d.cause = CAUSE_L2;
                        walk_d.pa = '0; walk_d.attr = '0;
                    end else begin
                        walk_d.fault = 1'b0; walk_d.cause = CAUSE_NONE;
                        walk_d.pa = l2_pa; walk_d.attr = l2_attr;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '{st: ST_IDLE, default: '0};
        end else begin
            walk_q <= walk_d;
        end
    end

    assign mem_req_o  = (walk_q.st != ST_IDLE);
    assign mem_addr_o = walk_q.maddr;
    assign done_o     = walk_q.done;
    assign paddr_o    = walk_q.pa;
    assign attr_o     = walk_q.attr;
    assign fault_o    = walk_q.fault;
    assign cause_o    = walk_q.cause;

    // R13: an outstanding read keeps its address until answered
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i && !mem_err_i |=> mem_req_o && $stable(mem_addr_o));

    // R12: completion is a single-cycle pulse
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R12: results only move on completion
    p_result_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(paddr_o) && $stable(cause_o) && $stable(attr_o));

    // R12: a start during a walk does not replace the captured address
    p_busy_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && start_i |=> $stable(walk_q.va));

    // R11: an error response ends the walk as a bus error
    p_bus_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_err_i |=> done_o && fault_o && cause_o == CAUSE_BUS && !mem_req_o);

    // R2: fault flag and cause code agree
    p_cause_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fault_o == (cause_o != CAUSE_NONE)));
endmodule

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] vaddr = '0, tbase = '0;
    logic        fine = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] paddr;
    logic [1:0]  attr;
    logic        fault;
    logic [1:0]  cause;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #5 clk = ~clk;

    xlat_walker u_xlat_walker (
        .clk(clk), .rst_n(rst_n), .start_i(start), .vaddr_i(vaddr), .tbase_i(tbase),
        .fine_en_i(fine), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_ack_i(mem_ack), .mem_err_i(mem_err), .mem_rdata_i(mem_rdata),
        .done_o(done), .paddr_o(paddr), .attr_o(attr), .fault_o(fault), .cause_o(cause)
    );

    // memory responder state
    logic [31:0] m_d1, m_d2;
    logic        m_e1, m_e2;
    logic [31:0] log_a [0:3];
    int          fetch_n = 0, wait_cnt = 0;

    always @(negedge clk) begin
        cyc++;
        if (mem_ack || mem_err) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt > 0) wait_cnt--;
            else begin
                if (fetch_n < 4) log_a[fetch_n] = mem_addr;
                if (fetch_n == 0) begin mem_rdata = m_d1; mem_err = m_e1; mem_ack = !m_e1; end
                else              begin mem_rdata = m_d2; mem_err = m_e2; mem_ack = !m_e2; end
                fetch_n++;
                wait_cnt = $urandom % 3;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        while (cyc < 150000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        finish_run();
    end

    // reference model written from the requirement list
    task automatic model(input logic [31:0] va, tb, input logic fe,
                         input logic [31:0] d1, d2, input logic e1, e2,
                         output logic [31:0] pa, output logic [1:0] at,
                         output logic [1:0] cs, output int nf,
                         output logic [31:0] a1, a2, output string tag);
        logic [1:0] t1, t2;
        pa = '0; at = '0; cs = 2'b00; nf = 1; a2 = '0;
        a1 = {tb[31:14], va[31:20], 2'b00};
        t1 = d1[1:0]; t2 = d2[1:0];
        if (e1) begin cs = 2'b11; tag = "R11"; return; end
        if (t1 == 2'd0) begin cs = 2'b01; tag = "R2"; return; end
        if (t1 == 2'd3 && !fe) begin cs = 2'b01; tag = "R3"; return; end
        if (t1 == 2'd2) begin pa = {d1[31:20], va[19:0]}; at = d1[3:2]; tag = "R4"; return; end
        nf = 2;
        if (t1 == 2'd1) begin a2 = {d1[31:10], va[19:12], 2'b00}; tag = "R5"; end
        else            begin a2 = {d1[31:12], va[19:10], 2'b00}; tag = "R6"; end
        if (e2) begin cs = 2'b11; tag = "R11"; return; end
        case (t2)
            2'd0: begin cs = 2'b10; tag = "R7"; end
            2'd1: begin pa = {d2[31:16], va[15:0]}; at = d2[3:2]; tag = "R8"; end
            2'd2: begin pa = {d2[31:12], va[11:0]}; at = d2[3:2]; tag = "R9"; end
            default: begin pa = {d2[31:10], va[9:0]}; at = d2[3:2]; tag = "R10"; end
        endcase
    endtask

    task automatic walk(input logic [31:0] va, tb, input logic fe,
                        input logic [31:0] d1, d2, input logic e1, e2, input logic busy_start);
        logic [31:0] pa, a1, a2, pa_seen;
        logic [1:0]  at, cs;
        int          nf, k;
        string       tag;
        model(va, tb, fe, d1, d2, e1, e2, pa, at, cs, nf, a1, a2, tag);
        m_d1 = d1; m_d2 = d2; m_e1 = e1; m_e2 = e2; fetch_n = 0;
        @(negedge clk);
        vaddr = va; tbase = tb; fine = fe; start = 1'b1;
        @(negedge clk);
        if (busy_start) begin vaddr = ~va; tbase = ~tb; fine = ~fe; end
        else start = 1'b0;
        k = 0;
        while (!done && k < 60) begin @(negedge clk); k++; end
        start = 1'b0;
        chk({tag, " done seen"}, 32'(done), 32'd1);
        chk({tag, " paddr"}, paddr, pa);
        chk({tag, " attr"}, 32'(attr), 32'(at));
        chk({tag, " fault"}, 32'(fault), 32'(cs != 2'b00));
        chk({tag, " cause"}, 32'(cause), 32'(cs));
        chk({tag, " fetch count"}, 32'(fetch_n), 32'(nf));
        chk("R1 first read address", log_a[0], a1);
        if (nf == 2) chk({tag, " second read address"}, log_a[1], a2);
        pa_seen = paddr;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (i == 0) chk("R12 done pulse width", 32'(done), 32'd0);
        end
        chk("R12 paddr held", paddr, pa_seen);
        chk("R12 no read after walk", 32'(fetch_n), 32'(nf));
    endtask

    initial begin
        logic [31:0] rva, rtb, rd1, rd2;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk("R13 reset done", 32'(done), 32'd0);
        chk("R13 reset req", 32'(mem_req), 32'd0);
        chk("R13 reset fault", 32'(fault), 32'd0);
        rst_n = 1'b1;
        // directed corners
        walk(32'h1234_5678, 32'hABCD_C000, 1'b0, 32'h0000_0000, 32'h0, 1'b0, 1'b0, 1'b0); // R2
        walk(32'h8765_4321, 32'h0000_4000, 1'b0, 32'hFFFF_F003, 32'h0, 1'b0, 1'b0, 1'b0); // R3
        walk(32'hFFF1_2345, 32'hFFFF_FFFF, 1'b0, 32'hA5A0_000E, 32'h0, 1'b0, 1'b0, 1'b0); // R4
        walk(32'h0FF1_2ABC, 32'h1000_0000, 1'b0, 32'h3333_3C01, 32'hDEAD_BEE5, 1'b0, 1'b0, 1'b0); // R5 R8
        walk(32'h0FFF_F3FF, 32'h1000_0000, 1'b1, 32'h4444_4003, 32'hCAFE_F00F, 1'b0, 1'b0, 1'b0); // R6 R10
        walk(32'h0001_2345, 32'h2000_0000, 1'b0, 32'h5555_5401, 32'h9999_900A, 1'b0, 1'b0, 1'b0); // R9
        walk(32'h0001_2345, 32'h2000_0000, 1'b0, 32'h5555_5401, 32'h9999_9000, 1'b0, 1'b0, 1'b0); // R7
        walk(32'h7777_7777, 32'h3000_0000, 1'b0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);               // R11 first
        walk(32'h7777_7777, 32'h3000_0000, 1'b1, 32'h6666_6003, 32'h1, 1'b0, 1'b1, 1'b0);        // R11 second
        walk(32'h4321_0FED, 32'h5000_0000, 1'b0, 32'h7700_0001, 32'h8800_0006, 1'b0, 1'b0, 1'b1); // R12 busy start
        walk(32'h0ABC_DEF0, 32'h5000_0000, 1'b1, 32'h1234_5002, 32'h0, 1'b0, 1'b0, 1'b1);        // R12 busy start
        // constrained random
        for (int n = 0; n < 300; n++) begin
            rva = $urandom; rtb = $urandom; rd1 = $urandom; rd2 = $urandom;
            walk(rva, rtb, 1'($urandom), rd1, rd2, ($urandom % 16) == 0,
                 ($urandom % 16) == 0, ($urandom % 5) == 0);
        end
        finish_run();
    end
endmodule